// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Tick Generator

This block turns one reference clock into the two timing strobes a serial port needs. A first divider counts reference clocks and emits a one-cycle sample strobe every CD clocks. A second divider counts those sample strobes and emits a one-cycle bit strobe on every (BDIV+1)-th of them, so the oversampling ratio is programmable instead of fixed. The bit rate is therefore f_clk / (CD × (BDIV+1)).

Software or a neighbouring register block loads the 16-bit clock divisor and the 8-bit oversampling divisor through two write strobes. Any write restarts both counters, so the new rate takes effect from a clean phase. A divisor of zero parks the generator; an oversampling divisor below the minimum is raised to that minimum.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the clock divisor is 0 and the oversampling divisor is 15, and both sample_tick and baud_tick stay low until a nonzero clock divisor is written.
- R2: With clock divisor CD ≥ 1, sample_tick is a single-cycle pulse that repeats every CD reference clocks; CD = 1 holds sample_tick high on every cycle.
- R3: A clock divisor of 0 keeps both sample_tick and baud_tick low.
- R4: baud_tick is high only in a cycle where sample_tick is also high, and it rises on every (BDIV+1)-th sample_tick, giving a bit period of CD × (BDIV+1) clocks.
- R5: An oversampling divisor written below 4 behaves as 4 (bit period CD × 5).
- R6: A write strobe on either divisor restarts both counters at that clock edge: the first sample_tick appears CD clocks and the first baud_tick CD × (BDIV+1) clocks after the write edge.
- R7: The largest oversampling divisor, 255, gives one baud_tick per 256 sample ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_wr | input | 1 | Load strobe for the clock divisor |
| cd_wdata | input | 16 | New clock divisor value |
| bdiv_wr | input | 1 | Load strobe for the oversampling divisor |
| bdiv_wdata | input | 8 | New oversampling divisor value |
| sample_tick | output | 1 | One-cycle pulse every CD clocks |
| baud_tick | output | 1 | One-cycle pulse every CD × (BDIV+1) clocks, coincident with a sample_tick |

## Verification
A corrupted clock-divider count shows as a sample_tick at the wrong cycle within at most CD clocks, and it shifts every later baud_tick with it. A wrong oversampling count or a missed clamp leaves sample_tick correct but moves baud_tick, which becomes visible by the end of the first bit period after the write. A missed restart shows on the very first tick after a write, since the phase then no longer lines up with the write edge.

// File: rtl/baud_pkg.sv
package baud_pkg;
    parameter int CD_W      = 16;
    parameter int BDIV_W    = 8;
    parameter int BDIV_MIN  = 4;
    parameter int CD_RST    = 0;
    parameter int BDIV_RST  = 15;

    typedef struct packed {
        logic [CD_W-1:0]   cd;
        logic [BDIV_W-1:0] bdiv;
    } div_regs_t;

    typedef struct packed {
        logic [CD_W-1:0] cnt;
        logic            tick;
    } presc_state_t;

    typedef struct packed {
        logic [BDIV_W-1:0] cnt;
        logic              tick;
    } bitcnt_state_t;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cd_wr,
    input  logic [CD_W-1:0]   cd_wdata,
    input  logic              bdiv_wr,
    input  logic [BDIV_W-1:0] bdiv_wdata,
    output logic [CD_W-1:0]   cd_val,
    output logic [BDIV_W-1:0] bdiv_val,
    output logic              restart
);
    localparam logic [BDIV_W-1:0] BDIV_FLOOR = BDIV_W'(BDIV_MIN);

    div_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cd_wr) begin
            r_d.cd = cd_wdata;
        end
        if (bdiv_wr) begin
            // Values below the floor are stored as the floor.
            r_d.bdiv = (bdiv_wdata < BDIV_FLOOR) ? BDIV_FLOOR : bdiv_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cd   <= CD_W'(CD_RST);
            r_q.bdiv <= BDIV_W'(BDIV_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign cd_val   = r_q.cd;
    assign bdiv_val = r_q.bdiv;
    assign restart  = cd_wr | bdiv_wr;

    // R5: the divisor seen by the bit counter never drops below the floor
    a_r5_bdiv_floor: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bdiv >= BDIV_FLOOR)
        else $error("oversampling divisor below floor");

    // R6: a write lands in the register on the following cycle
    a_r6_cd_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        cd_wr |=> (cd_val == $past(cd_wdata)))
        else $error("clock divisor not loaded");
endmodule

// File: rtl/baud_presc.sv
module baud_presc
    import baud_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CD_W-1:0] cd_val,
    input  logic            restart,
    output logic            fire,
    output logic            sample_tick
);
    localparam logic [CD_W-1:0] ONE = CD_W'(1);

    presc_state_t s_d, s_q;
    logic         running;

    always_comb begin
        running = (cd_val != '0);
        fire    = running && (s_q.cnt == cd_val - ONE) && !restart;
        s_d     = s_q;
        if (restart || !running || fire) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + ONE;
        end
        s_d.tick = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sample_tick = s_q.tick;

    // R3: a zero divisor produces no sample strobe
    a_r3_idle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_val == '0) |=> !sample_tick)
        else $error("sample tick with zero divisor");

    // R2: with CD above one the strobe lasts a single cycle
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && cd_val > ONE) |=> !sample_tick)
        else $error("sample tick wider than one cycle");

    // R6: the cycle after a write carries no strobe
    a_r6_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sample_tick)
        else $error("sample tick right after restart");
endmodule

// File: rtl/baud_bitcnt.sv
module baud_bitcnt
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BDIV_W-1:0] bdiv_val,
    input  logic              restart,
    input  logic              fire,
    output logic              baud_tick
);
    localparam logic [BDIV_W-1:0] ONE = BDIV_W'(1);

    bitcnt_state_t s_d, s_q;
    logic          last;

    always_comb begin
        last = (s_q.cnt == bdiv_val);
        s_d  = s_q;
        if (restart) begin
            s_d.cnt = '0;
        end else if (fire) begin
            s_d.cnt = last ? '0 : s_q.cnt + ONE;
        end
        s_d.tick = fire && last && !restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign baud_tick = s_q.tick;

    // R4: the sample counter never runs past the programmed ratio
    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= bdiv_val)
        else $error("bit counter out of range");
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cd_wr,
    input  logic [CD_W-1:0]   cd_wdata,
    input  logic              bdiv_wr,
    input  logic [BDIV_W-1:0] bdiv_wdata,
    output logic              sample_tick,
    output logic              baud_tick
);
    logic [CD_W-1:0]   cd_val;
    logic [BDIV_W-1:0] bdiv_val;
    logic              restart;
    logic              fire;

    baud_div_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cd_wr      (cd_wr),
        .cd_wdata   (cd_wdata),
        .bdiv_wr    (bdiv_wr),
        .bdiv_wdata (bdiv_wdata),
        .cd_val     (cd_val),
        .bdiv_val   (bdiv_val),
        .restart    (restart)
    );

    baud_presc u_presc (
        .clk         (clk),
        .rst_n       (rst_n),
        .cd_val      (cd_val),
        .restart     (restart),
        .fire        (fire),
        .sample_tick (sample_tick)
    );

    baud_bitcnt u_bitcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bdiv_val  (bdiv_val),
        .restart   (restart),
        .fire      (fire),
        .baud_tick (baud_tick)
    );

    // R4: a bit strobe always coincides with a sample strobe
    a_r4_baud_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> sample_tick)
        else $error("baud tick without sample tick");

    // R3: both outputs quiet while the divisor is zero
    a_r3_baud_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_val == '0) |=> !baud_tick)
        else $error("baud tick with zero divisor");
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cd_wr = 1'b0;
    logic [15:0] cd_wdata = '0;
    logic        bdiv_wr = 1'b0;
    logic [7:0]  bdiv_wdata = '0;
    logic        sample_tick;
    logic        baud_tick;

    baud_tick_gen dut (
        .clk (clk), .rst_n (rst_n),
        .cd_wr (cd_wr), .cd_wdata (cd_wdata),
        .bdiv_wr (bdiv_wr), .bdiv_wdata (bdiv_wdata),
        .sample_tick (sample_tick), .baud_tick (baud_tick)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string tag      = "R1";

    // Behavioural model: clocks elapsed since the last restart edge
    int m_cd   = 0;
    int m_bdiv = 15;
    int m_k    = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cd = 0; m_bdiv = 15; m_k = 0;
        end else if (cd_wr || bdiv_wr) begin
            if (cd_wr) m_cd = int'(cd_wdata);
            if (bdiv_wr) m_bdiv = (int'(bdiv_wdata) < 4) ? 4 : int'(bdiv_wdata);
            m_k = 0;
        end else begin
            m_k++;
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic exp_s, exp_b;
        exp_s = (m_cd != 0) && (m_k > 0) && (m_k % m_cd == 0);
        exp_b = (m_cd != 0) && (m_k > 0) && (m_k % (m_cd * (m_bdiv + 1)) == 0);
        check(tag, sample_tick, exp_s, "sample_tick");
        check(tag, baud_tick, exp_b, "baud_tick");
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
            $finish;
        end
    end

    task automatic wr_cd(input int v);
        @(negedge clk); cd_wr = 1'b1; cd_wdata = 16'(v);
        @(negedge clk); cd_wr = 1'b0;
    endtask

    task automatic wr_bdiv(input int v);
        @(negedge clk); bdiv_wr = 1'b1; bdiv_wdata = 8'(v);
        @(negedge clk); bdiv_wr = 1'b0;
    endtask

    task automatic wr_both(input int c, input int b);
        @(negedge clk); cd_wr = 1'b1; cd_wdata = 16'(c); bdiv_wr = 1'b1; bdiv_wdata = 8'(b);
        @(negedge clk); cd_wr = 1'b0; bdiv_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state and quiet outputs with the default divisor
        tag = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(40);
        tag = "R1";
        wr_bdiv(7);            // still CD = 0, nothing may tick
        idle(30);
        // R2: CD = 1 gives a strobe every clock, BDIV 4 -> baud every 5
        tag = "R2";
        wr_both(1, 4);
        idle(40);
        // R2: CD = 7 with default-sized ratio
        tag = "R2";
        wr_both(7, 15);
        idle(250);
        // R5: oversampling divisor below the floor clamps to 4
        tag = "R5";
        wr_both(3, 2);
        idle(60);
        tag = "R5";
        wr_bdiv(0);
        idle(60);
        // R6: restart in the middle of a bit period
        tag = "R6";
        wr_both(5, 6);
        idle(17);
        wr_cd(4);
        idle(9);
        wr_bdiv(5);
        idle(60);
        // R3: zero divisor stops both outputs
        tag = "R3";
        wr_cd(0);
        idle(50);
        // R7: maximum ratio
        tag = "R7";
        wr_both(1, 255);
        idle(600);
        // R4: large clock divisor, bit period CD*(BDIV+1)
        tag = "R4";
        wr_both(300, 4);
        idle(3200);
        tag = "R4";
        wr_both(2, 9);
        idle(100);
        summary();
        $finish;
    end
endmodule